// File: doc/BRIEF.md
# Read Prefetch Line Buffer for a Bus Target

This block sits between the target side of a bus interface and local memory and supplies read data to an external master one 32-bit word at a time. It keeps two line buffers of 32 bytes each. One buffer is the demand line: it holds the line the master is reading now. The other is the look-ahead line. When a word is requested, its line address is compared with the tags of both buffers. A hit returns the word in the same cycle. A miss raises a stall and starts a burst read of the whole line from local memory.

For requests that decode to the prefetchable window, the block fetches the next sequential line into the look-ahead buffer while the master is still consuming the demand line. This happens when the command is the multiple-line read code or when the prefetch force control is set. When the master moves on to that next line, the two buffers swap roles. The old demand buffer is dropped and becomes the target of the next look-ahead fetch. Both buffers are emptied when the master flushes, when the transaction ends, or when a posted write to local memory is accepted, so stale data is never returned.

Top module: `pci_rd_prefetch`

## Requirements
- R1: While reset is held and right after it is released, `rd_valid`, `stall` and `mem_req` are all low.
- R2: A request whose line is in neither buffer causes one burst read. `mem_addr` carries the request address with bits 4:0 cleared. `mem_req` stays high with a stable address until `mem_gnt`, and eight beats then fill words 0 to 7 of the line in arrival order.
- R3: While the requested line is not fully present, `stall` is high and `rd_valid` is low. Once the line is present, `rd_valid` is high with no stall, and `rd_data` is the word chosen by address bits 4:2. `rd_valid` and `stall` are never high together, and `stall` is high only for an active request.
- R4: A request served from the demand buffer starts a look-ahead fetch of line address plus 32 into the other buffer. This happens when `req_pf_win` is high and either `req_cmd` equals 4'hC or `req_pf_force` is high.
- R5: No look-ahead fetch is started when `req_pf_win` is low, or when `req_cmd` is not 4'hC and `req_pf_force` is low.
- R6: A request that hits the look-ahead buffer is served with no stall and no new read of that line. The buffers then swap roles, and the next served word starts a look-ahead fetch of the following line.
- R7: An accepted `wr_post` empties both buffers, so the next request stalls and re-reads its line. A line fill whose last beat arrives in the same cycle as `wr_post`, or that was in flight when it came, is discarded.
- R8: A pulse on `mst_flush`, or `frame_active` going low, empties both buffers in the same way. The cycle after either, `rd_valid` is low.
- R9: At most one burst is outstanding: `mem_req` is never raised while beats of an earlier burst are still due. A miss that arrives during a look-ahead fetch waits for it to finish.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Master requests the word at `req_addr`; held until `rd_valid` |
| req_addr | input | 32 | Byte address of the requested word |
| req_cmd | input | 4 | Bus read command code; 4'hC is the multiple-line read |
| req_pf_win | input | 1 | Request decodes to the prefetchable window |
| req_pf_force | input | 1 | Control bit enabling look-ahead for any read command |
| frame_active | input | 1 | High while the master's transaction is in progress |
| mst_flush | input | 1 | Master discards buffered read data |
| wr_post | input | 1 | A posted write to local memory was accepted |
| rd_valid | output | 1 | `rd_data` holds the requested word this cycle |
| rd_data | output | 32 | Returned word |
| stall | output | 1 | Request active but its line is not present |
| mem_req | output | 1 | Burst read request to local memory |
| mem_addr | output | 32 | Line-aligned burst address |
| mem_gnt | input | 1 | Memory accepts the burst request |
| mem_rvalid | input | 1 | A data beat is on `mem_rdata` |
| mem_rdata | input | 32 | Burst data beat |

## Verification
The sharpest collision is between emptying the buffers and the completion of a look-ahead fill. If a posted write is accepted in the very cycle the last beat of a speculative line arrives, the fill must not mark that line present. The bench's memory model provokes this by raising `wr_post` on the final beat of a chosen look-ahead burst and changing its stored data at that moment. The next request to that line must then stall, issue a fresh burst for the same address, and return the new data rather than the copy taken before the write.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

   // fetch engine states
   typedef enum logic [1:0] {
      FE_IDLE,
      FE_ADDR,
      FE_DATA
   } fe_state_e;

   // command code of the multiple-line read
   localparam logic [3:0] CMD_RD_MULTI = 4'hC;

endpackage

// File: rtl/pfb_line_buf.sv
module pfb_line_buf #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   parameter int TAG_W  = 27,
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fill_start,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic              wr_en,
   input  logic [WSEL_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fill_done,
   input  logic [WSEL_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              valid,
   output logic [TAG_W-1:0]  tag
);

   logic [DATA_W-1:0] word_q [WORDS];
   logic              valid_q;
   logic [TAG_W-1:0]  tag_q;

   // storage carries no reset: valid guards every read
   always_ff @(posedge clk) begin
      if (wr_en) word_q[wr_idx] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
      end else begin
         if (fill_start) tag_q <= fill_tag;
         if (clr || fill_start) valid_q <= 1'b0;
         else if (fill_done)    valid_q <= 1'b1;
      end
   end

   assign rd_data = word_q[rd_idx];
   assign valid   = valid_q;
   assign tag     = tag_q;

endmodule

// File: rtl/pfb_fetch.sv
module pfb_fetch
   import pfb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   parameter int OFF_W  = 5,
   localparam int TAG_W  = ADDR_W - OFF_W,
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TAG_W-1:0]  start_tag,
   input  logic              start_buf,
   input  logic              kill,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wr_en,
   output logic [WSEL_W-1:0] wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_buf,
   output logic              done_ok
);

   fe_state_e         st_q;
   logic [TAG_W-1:0]  tag_q;
   logic              buf_q;
   logic [WSEL_W-1:0] cnt_q;
   logic              kill_q;
   logic              beat;
   logic              last;

   assign busy     = (st_q != FE_IDLE);
   assign mem_req  = (st_q == FE_ADDR);
   assign mem_addr = {tag_q, {OFF_W{1'b0}}};
   assign beat     = (st_q == FE_DATA) && mem_rvalid;
   assign last     = beat && (cnt_q == WSEL_W'(WORDS - 1));
   assign wr_en    = beat && !kill_q;
   assign wr_idx   = cnt_q;
   assign wr_data  = mem_rdata;
   assign wr_buf   = buf_q;
   assign done_ok  = last && !kill_q && !kill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FE_IDLE;
         tag_q  <= '0;
         buf_q  <= 1'b0;
         cnt_q  <= '0;
         kill_q <= 1'b0;
      end else begin
         unique case (st_q)
            FE_IDLE: begin
               if (start) begin
                  st_q   <= FE_ADDR;
                  tag_q  <= start_tag;
                  buf_q  <= start_buf;
                  kill_q <= 1'b0;
               end
            end
            FE_ADDR: begin
               if (kill) kill_q <= 1'b1;
               if (mem_gnt) begin
                  st_q  <= FE_DATA;
                  cnt_q <= '0;
               end
            end
            FE_DATA: begin
               if (kill) kill_q <= 1'b1;
               if (beat) cnt_q <= cnt_q + 1'b1;
               if (last) st_q <= FE_IDLE;
            end
            default: st_q <= FE_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pci_rd_prefetch.sv
module pci_rd_prefetch
   import pfb_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          DATA_W     = 32,
   parameter int          LINE_BYTES = 32,
   parameter bit          SPEC_EN    = 1'b1,
   parameter logic [3:0]  MULTI_CMD  = CMD_RD_MULTI,
   localparam int BYTES_W = DATA_W / 8,
   localparam int WORDS   = LINE_BYTES / BYTES_W,
   localparam int OFF_W   = $clog2(LINE_BYTES),
   localparam int BSEL_W  = $clog2(BYTES_W),
   localparam int WSEL_W  = $clog2(WORDS),
   localparam int TAG_W   = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_cmd,
   input  logic              req_pf_win,
   input  logic              req_pf_force,
   input  logic              frame_active,
   input  logic              mst_flush,
   input  logic              wr_post,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              stall,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);

   // elaboration checks on the parameter set
   if ((DATA_W % 8) != 0 || DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8, at least 16");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || WORDS < 2) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding two or more words");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr_w
      $error("ADDR_W must exceed the line offset width");
   end

   // request decode
   logic [TAG_W-1:0]  req_line;
   logic [TAG_W-1:0]  next_line;
   logic [WSEL_W-1:0] req_word;
   logic              unused_lsb;

   assign req_line   = req_addr[ADDR_W-1:OFF_W];
   assign next_line  = req_line + 1'b1;
   assign req_word   = req_addr[OFF_W-1:BSEL_W];
   assign unused_lsb = ^req_addr[BSEL_W-1:0];

   // buffer state
   logic              cur_q;
   logic              oth;
   logic [1:0]        bv;
   logic [TAG_W-1:0]  btag  [2];
   logic [DATA_W-1:0] bdata [2];
   logic [1:0]        hit_b;
   logic [1:0]        b_clr, b_start, b_wr, b_done;

   // fetch engine side
   logic              f_start, f_busy, f_buf, f_wr, f_done;
   logic [TAG_W-1:0]  f_tag;
   logic [WSEL_W-1:0] f_idx;
   logic [DATA_W-1:0] f_data;

   // control
   logic active, inval, hit_cur, hit_oth, swap;
   logic want_pf, oth_has_next, dem_go, spec_go;

   assign oth    = ~cur_q;
   assign active = req_valid && frame_active;
   assign inval  = !frame_active || mst_flush || wr_post;

   assign hit_cur  = active && hit_b[cur_q];
   assign hit_oth  = active && hit_b[oth] && !hit_b[cur_q];
   assign swap     = hit_oth;
   assign rd_valid = hit_cur || hit_oth;
   assign stall    = active && !rd_valid;
   assign rd_data  = bdata[hit_oth ? oth : cur_q];

   assign want_pf      = req_pf_win && ((req_cmd == MULTI_CMD) || req_pf_force);
   assign oth_has_next = bv[oth] && (btag[oth] == next_line);
   assign dem_go       = stall && !f_busy && !inval;

   if (SPEC_EN) begin : g_spec
      assign spec_go = hit_cur && want_pf && !f_busy && !inval && !oth_has_next;
   end else begin : g_nospec
      assign spec_go = 1'b0;
   end

   assign f_start = dem_go || spec_go;
   assign f_tag   = dem_go ? req_line : next_line;

   logic start_buf;
   assign start_buf = dem_go ? cur_q : oth;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= 1'b0;
      else if (swap) cur_q <= oth;
   end

   for (genvar i = 0; i < 2; i++) begin : g_buf
      assign hit_b[i]   = bv[i] && (btag[i] == req_line);
      assign b_clr[i]   = inval || (swap && (cur_q == 1'(i)));
      assign b_start[i] = f_start && (start_buf == 1'(i));
      assign b_wr[i]    = f_wr && (f_buf == 1'(i));
      assign b_done[i]  = f_done && (f_buf == 1'(i)) && !inval;

      pfb_line_buf #(
         .DATA_W (DATA_W),
         .WORDS  (WORDS),
         .TAG_W  (TAG_W)
      ) u_line (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (b_clr[i]),
         .fill_start (b_start[i]),
         .fill_tag   (f_tag),
         .wr_en      (b_wr[i]),
         .wr_idx     (f_idx),
         .wr_data    (f_data),
         .fill_done  (b_done[i]),
         .rd_idx     (req_word),
         .rd_data    (bdata[i]),
         .valid      (bv[i]),
         .tag        (btag[i])
      );
   end

   pfb_fetch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WORDS  (WORDS),
      .OFF_W  (OFF_W)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (f_start),
      .start_tag  (f_tag),
      .start_buf  (start_buf),
      .kill       (inval),
      .busy       (f_busy),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .wr_en      (f_wr),
      .wr_idx     (f_idx),
      .wr_data    (f_data),
      .wr_buf     (f_buf),
      .done_ok    (f_done)
   );

endmodule

// File: rtl/pci_rd_prefetch_chk.sv
module pci_rd_prefetch_chk #(
   parameter int         ADDR_W    = 32,
   parameter int         WORDS     = 8,
   parameter int         OFF_W     = 5,
   parameter logic [3:0] MULTI_CMD = 4'hC,
   localparam int CNT_W = $clog2(WORDS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [3:0]        req_cmd,
   input logic              req_pf_win,
   input logic              req_pf_force,
   input logic              frame_active,
   input logic              mst_flush,
   input logic              wr_post,
   input logic              rd_valid,
   input logic              stall,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_gnt,
   input logic              mem_rvalid
);

   // beats still owed by memory, tracked from the port handshake
   logic [CNT_W-1:0] owed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owed_q <= '0;
      else if (mem_req && mem_gnt) owed_q <= CNT_W'(WORDS);
      else if (mem_rvalid && owed_q != '0) owed_q <= owed_q - 1'b1;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R2

   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[OFF_W-1:0] == '0); // R2

   AST_VALID_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && stall)); // R3

   AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> req_valid && frame_active); // R3

   AST_SPEC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) && $past(rd_valid) |->
         $past(req_pf_win && (req_cmd == MULTI_CMD || req_pf_force))); // R5

   AST_WRITE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_post |=> !rd_valid); // R7

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_flush || !frame_active) |=> !rd_valid); // R8

   AST_ONE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      owed_q != '0 |-> !mem_req); // R9

endmodule

bind pci_rd_prefetch pci_rd_prefetch_chk #(
   .ADDR_W    (ADDR_W),
   .WORDS     (WORDS),
   .OFF_W     (OFF_W),
   .MULTI_CMD (MULTI_CMD)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_cmd      (req_cmd),
   .req_pf_win   (req_pf_win),
   .req_pf_force (req_pf_force),
   .frame_active (frame_active),
   .mst_flush    (mst_flush),
   .wr_post      (wr_post),
   .rd_valid     (rd_valid),
   .stall        (stall),
   .mem_req      (mem_req),
   .mem_addr     (mem_addr),
   .mem_gnt      (mem_gnt),
   .mem_rvalid   (mem_rvalid)
);

// File: tb/pci_rd_prefetch_tb.sv
`timescale 1ns/1ps
module pci_rd_prefetch_tb;

   localparam int GNT_LAT = 2;
   localparam logic [3:0] CMD_MR  = 4'h6;
   localparam logic [3:0] CMD_MRM = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_pf_win, req_pf_force, frame_active, mst_flush, wr_post;
   logic [31:0] req_addr;
   logic [3:0]  req_cmd;
   logic        rd_valid, stall, mem_req, mem_gnt, mem_rvalid;
   logic [31:0] rd_data, mem_addr, mem_rdata;

   always #4 clk = ~clk;   // 125 MHz

   pci_rd_prefetch u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_cmd(req_cmd), .req_pf_win(req_pf_win), .req_pf_force(req_pf_force),
      .frame_active(frame_active), .mst_flush(mst_flush), .wr_post(wr_post),
      .rd_valid(rd_valid), .rd_data(rd_data), .stall(stall),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // memory model state
   logic [31:0] key = 32'h0;
   int          fetch_cnt = 0;
   int          overlap_err = 0;
   int          post_at_fetch = -1;
   logic [31:0] fetch_log [$];

   typedef struct {
      logic [31:0] d;
      string       tag;
   } exp_t;
   exp_t exp_q [$];

   function automatic logic [31:0] mem_word(logic [31:0] a);
      return {a[31:2], 2'b00} ^ key ^ 32'h3C5A_0F96;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory responder: grant after a latency, then eight beats
   initial begin : mem_model
      logic [31:0] fa;
      bit posted;
      mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (rst_n && mem_req) begin
            fa = mem_addr;
            fetch_cnt++;
            fetch_log.push_back(fa);
            repeat (GNT_LAT) @(negedge clk);
            mem_gnt = 1'b1;
            @(negedge clk);
            mem_gnt = 1'b0;
            for (int b = 0; b < 8; b++) begin
               if (mem_req) overlap_err++;
               mem_rvalid = 1'b1;
               mem_rdata  = mem_word(fa + 32'(b * 4));
               posted = (b == 7) && (fetch_cnt == post_at_fetch);
               if (posted) begin
                  wr_post = 1'b1;
                  key = key + 32'h0101_0101;
               end
               @(negedge clk);
               mem_rvalid = 1'b0;
               if (posted) wr_post = 1'b0;
            end
         end
      end
   end

   // monitor: each served word is compared with the oldest expected item
   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected word", rd_data, 32'h0);
            end else begin
               e = exp_q.pop_front();
               chk(rd_data == e.d, e.tag, "returned word", rd_data, e.d);
            end
         end
      end
   end

   // driver: issue one word request, hold it until served
   task automatic rd(input logic [31:0] a, input logic [3:0] cmd, input bit win,
                     input bit frc, input string tag, output int stalls);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_cmd = cmd;
      req_pf_win = win; req_pf_force = frc;
      exp_q.push_back('{mem_word(a), tag});
      stalls = 0;
      forever begin
         #2;
         if (rd_valid) break;
         if (!stall) chk(1'b0, "R3", "no stall while unserved", 32'(stall), 32'h1);
         stalls++;
         if (stalls > 200) begin
            chk(1'b0, tag, "request never served", 32'(stalls), 32'h0);
            break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic end_frame();
      @(negedge clk); frame_active = 1'b0;
      @(negedge clk); frame_active = 1'b1;
   endtask

   task automatic post_write();
      @(negedge clk); wr_post = 1'b1; key = key + 32'h0101_0101;
      @(negedge clk); wr_post = 1'b0;
   endtask

   task automatic flush_pulse();
      @(negedge clk); mst_flush = 1'b1;
      @(negedge clk); mst_flush = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         summary();
         $finish;
      end
   end

   initial begin : main
      int s;
      int base;
      logic [31:0] la, lb, lc, ld, le, lf, lg, lh;
      la = 32'h1000_0040; lb = 32'h2000_0100; lc = 32'h3000_0000; ld = 32'h4000_07E0;
      le = 32'h5000_0200; lf = 32'h6000_0060; lg = 32'h7000_0400; lh = 32'h0800_1000;

      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_cmd = CMD_MR;
      req_pf_win = 1'b0; req_pf_force = 1'b0; frame_active = 1'b1;
      mst_flush = 1'b0; wr_post = 1'b0;

      // R1: quiet during and after reset
      idle(4);
      #2;
      chk(!rd_valid && !stall && !mem_req, "R1", "outputs in reset",
          {29'h0, rd_valid, stall, mem_req}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      idle(3);
      #2;
      chk(!rd_valid && !stall && !mem_req && fetch_cnt == 0, "R1", "outputs after reset",
          {29'h0, rd_valid, stall, mem_req}, 32'h0);

      // R2 R3 R5: plain read in the prefetchable window, no force
      base = fetch_cnt;
      rd(la + 12, CMD_MR, 1'b1, 1'b0, "R3", s);
      chk(s > 0, "R3", "first access stalls", 32'(s), 32'h1);
      chk(fetch_cnt == base + 1, "R2", "one burst on miss", 32'(fetch_cnt - base), 32'h1);
      chk(fetch_log[$] == la, "R2", "burst address aligned", fetch_log[$], la);
      rd(la + 28, CMD_MR, 1'b1, 1'b0, "R3", s);
      chk(s == 0, "R3", "word 7 served at once", 32'(s), 32'h0);
      rd(la + 0, CMD_MR, 1'b1, 1'b0, "R3", s);
      rd(la + 20, CMD_MR, 1'b1, 1'b0, "R3", s);
      chk(s == 0, "R3", "word 5 served at once", 32'(s), 32'h0);
      idle(20);
      chk(fetch_cnt == base + 1, "R5", "no look-ahead for plain read",
          32'(fetch_cnt - base), 32'h1);
      rd(la + 32, CMD_MR, 1'b1, 1'b0, "R2", s);
      chk(s > 0, "R2", "next line misses", 32'(s), 32'h1);
      chk(fetch_log[$] == la + 32, "R2", "next line burst address", fetch_log[$], la + 32);

      // R5 R8: multiple-line read outside the window
      end_frame();
      base = fetch_cnt;
      rd(lb, CMD_MRM, 1'b0, 1'b0, "R8", s);
      chk(s > 0, "R8", "frame end emptied buffers", 32'(s), 32'h1);
      idle(20);
      chk(fetch_cnt == base + 1, "R5", "no look-ahead outside window",
          32'(fetch_cnt - base), 32'h1);

      // R4 R6: multiple-line read streams across a line boundary
      end_frame();
      base = fetch_cnt;
      rd(lc, CMD_MRM, 1'b1, 1'b0, "R4", s);
      idle(20);
      chk(fetch_cnt == base + 2, "R4", "look-ahead started", 32'(fetch_cnt - base), 32'h2);
      chk(fetch_log[$] == lc + 32, "R4", "look-ahead address", fetch_log[$], lc + 32);
      for (int w = 1; w < 8; w++) rd(lc + 32'(4 * w), CMD_MRM, 1'b1, 1'b0, "R4", s);
      for (int w = 0; w < 8; w++) begin
         rd(lc + 32 + 32'(4 * w), CMD_MRM, 1'b1, 1'b0, "R6", s);
         if (w == 0) chk(s == 0, "R6", "second buffer hit without stall", 32'(s), 32'h0);
      end
      idle(20);
      chk(fetch_cnt == base + 3, "R6", "no re-read after swap", 32'(fetch_cnt - base), 32'h3);
      chk(fetch_log[$] == lc + 64, "R6", "look-ahead after swap", fetch_log[$], lc + 64);

      // R4: force bit with a plain read
      end_frame();
      base = fetch_cnt;
      rd(ld, CMD_MR, 1'b1, 1'b1, "R4", s);
      idle(20);
      chk(fetch_cnt == base + 2, "R4", "forced look-ahead", 32'(fetch_cnt - base), 32'h2);
      chk(fetch_log[$] == ld + 32, "R4", "forced look-ahead address", fetch_log[$], ld + 32);

      // R7: posted write empties both buffers
      post_write();
      base = fetch_cnt;
      rd(ld + 4, CMD_MR, 1'b1, 1'b1, "R7", s);
      chk(s > 0, "R7", "stall after posted write", 32'(s), 32'h1);
      chk(fetch_log[base] == ld, "R7", "line read again", fetch_log[base], ld);
      idle(20);

      // R7: write lands on the last beat of a look-ahead fill
      end_frame();
      base = fetch_cnt;
      post_at_fetch = base + 2;
      rd(le, CMD_MRM, 1'b1, 1'b0, "R7", s);
      idle(20);
      post_at_fetch = -1;
      chk(fetch_cnt == base + 2, "R7", "look-ahead ran", 32'(fetch_cnt - base), 32'h2);
      rd(le + 32, CMD_MRM, 1'b1, 1'b0, "R7", s);
      chk(s > 0, "R7", "racing fill discarded", 32'(s), 32'h1);
      chk(fetch_log[base + 2] == le + 32, "R7", "discarded line re-read",
          fetch_log[base + 2], le + 32);
      idle(20);

      // R8: master flush and frame end
      end_frame();
      base = fetch_cnt;
      rd(lf, CMD_MR, 1'b1, 1'b0, "R8", s);
      flush_pulse();
      rd(lf + 4, CMD_MR, 1'b1, 1'b0, "R8", s);
      chk(s > 0, "R8", "stall after flush", 32'(s), 32'h1);
      chk(fetch_cnt == base + 2, "R8", "re-read after flush", 32'(fetch_cnt - base), 32'h2);
      end_frame();
      rd(lf + 8, CMD_MR, 1'b1, 1'b0, "R8", s);
      chk(s > 0, "R8", "stall after frame end", 32'(s), 32'h1);
      chk(fetch_cnt == base + 3, "R8", "re-read after frame end",
          32'(fetch_cnt - base), 32'h3);

      // R9: a miss during an outstanding look-ahead waits for it
      end_frame();
      base = fetch_cnt;
      rd(lg, CMD_MRM, 1'b1, 1'b0, "R9", s);
      rd(lh, CMD_MR, 1'b0, 1'b0, "R9", s);
      chk(s > 0, "R9", "unrelated miss stalls", 32'(s), 32'h1);
      idle(20);
      chk(fetch_cnt == base + 3, "R9", "three bursts", 32'(fetch_cnt - base), 32'h3);
      chk(fetch_log[base + 1] == lg + 32, "R9", "look-ahead first", fetch_log[base + 1], lg + 32);
      chk(fetch_log[base + 2] == lh, "R9", "demand after", fetch_log[base + 2], lh);
      chk(overlap_err == 0, "R9", "request during burst", 32'(overlap_err), 32'h0);

      idle(4);
      chk(exp_q.size() == 0, "R3", "every request served", 32'(exp_q.size()), 32'h0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule